// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block drives an 8-bit general-purpose I/O port from a small host register interface. Software programs a direction register and an output data register. A read-only pin view returns, bit by bit, either the latched output data (for output bits) or the synchronized pad level (for input bits). The block does not drive pads itself. It presents a per-pin output-enable vector and an output-value vector, and the pad ring turns a disabled pin into high impedance.

Two kinds of reset and two kinds of standby act on the register file. An asynchronous power-on reset and hardware standby clear both registers, so every pin comes up as an input. A manual reset and software standby keep both registers as they are. Two alternate functions can override the registers. While an external bus controller claims the low three pins, those pins follow its enable and value inputs. In clock-output mode, an output-enabled top pin carries the system clock level in place of its data bit.

Top module: `gpio_port_ctl`

## Requirements
- R1: After the asynchronous power-on reset, the direction register and the data register both read 0x00 and every bit of pin_oe is 0.
- R2: A write with address 0 (direction) or address 1 (data) updates that register at the next rising clock edge. rdata is combinational: in the same cycle it shows the register selected by addr.
- R3: With no override active, pin_oe[i] equals direction bit i, and pin_out[i] equals data bit i.
- R4: A read of address 2 (pin view) returns, for each bit, the data bit when the direction bit is 1, and otherwise the pin_in level as sampled through two flops. A pin change therefore shows up after the second rising edge, not after the first.
- R5: A write to address 2 or address 3 changes neither register. A read of address 3 returns 0x00.
- R6: While hw_stby is high, every pin_oe bit is 0, host writes are ignored, and both registers are cleared at each clock edge. They still read 0x00 after hw_stby falls.
- R7: While man_rst is high, both registers keep their values and host writes are ignored.
- R8: While sw_stby is high, both registers keep their values, host writes are ignored, and pin_oe and pin_out keep their values.
- R9: While bus_claim is high and hw_stby is low, pin_oe[2:0] equals bus_oe and pin_out[2:0] equals bus_out. The direction and data registers are not changed by this.
- R10: While clk_mode is high and direction bit 7 is 1, pin_out[7] follows sysclk_lvl. With direction bit 7 at 0, pin_oe[7] is 0. Pins 6..0 behave as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hw_stby | input | 1 | Hardware standby: clear registers and release all pins |
| sw_stby | input | 1 | Software standby: hold registers and outputs |
| man_rst | input | 1 | Manual reset: hold registers, block writes |
| clk_mode | input | 1 | Enables the clock output on pin 7 |
| sysclk_lvl | input | 1 | System clock level for pin 7 |
| bus_claim | input | 1 | Bus controller owns pins 2..0 |
| bus_oe | input | 3 | Bus controller output enables for pins 2..0 |
| bus_out | input | 3 | Bus controller output values for pins 2..0 |
| addr | input | 2 | Register select: 0 direction, 1 data, 2 pin view |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
A table of direction, data and pin patterns exercises the per-bit read selection. The patterns are all-input, all-output, split upper/lower halves in both orientations, and an interleaved mask. Each of them separates a bit that should come from the data register from one that should come from the pad. Because the data and pad values in every row differ, the pin view shows which source was chosen for each bit, and the same rows also check the enable and value vectors. Directed cases then cover the synchronizer delay, each standby and reset kind (holding or clearing), and both overrides. For each override the bench also reads back the register it must not disturb.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_PINS = 2'd2,
    ADDR_NONE = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             hold,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] data_q
);
  logic [WIDTH-1:0] dir_d, data_d;
  logic             wr_ok;
  gpio_addr_e       sel;

  always_comb begin
    sel    = gpio_addr_e'(addr);
    wr_ok  = wr_en && !hold && !hw_stby;
    dir_d  = dir_q;
    data_d = data_q;
    if (hw_stby) begin
      dir_d  = '0;
      data_d = '0;
    end else if (wr_ok) begin
      if (sel == ADDR_DIR)  dir_d  = wdata;
      if (sel == ADDR_DATA) data_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      dir_q  <= dir_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
  parameter int WIDTH    = 8,
  parameter int BUS_PINS = 3
) (
  input  logic                hw_stby,
  input  logic                bus_claim,
  input  logic [BUS_PINS-1:0] bus_oe,
  input  logic [BUS_PINS-1:0] bus_out,
  input  logic                clk_mode,
  input  logic                sysclk_lvl,
  input  logic [WIDTH-1:0]    dir_q,
  input  logic [WIDTH-1:0]    data_q,
  output logic [WIDTH-1:0]    pin_oe,
  output logic [WIDTH-1:0]    pin_out
);
  localparam int CLK_PIN = WIDTH - 1;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      if (i < BUS_PINS) begin : g_bus
        always_comb begin
          if (hw_stby) begin
            pin_oe[i]  = 1'b0;
            pin_out[i] = data_q[i];
          end else if (bus_claim) begin
            pin_oe[i]  = bus_oe[i];
            pin_out[i] = bus_out[i];
          end else begin
            pin_oe[i]  = dir_q[i];
            pin_out[i] = data_q[i];
          end
        end
      end else if (i == CLK_PIN) begin : g_clk
        always_comb begin
          pin_oe[i]  = dir_q[i] && !hw_stby;
          pin_out[i] = (clk_mode && dir_q[i]) ? sysclk_lvl : data_q[i];
        end
      end else begin : g_plain
        always_comb begin
          pin_oe[i]  = dir_q[i] && !hw_stby;
          pin_out[i] = data_q[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int BUS_PINS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_stby,
  input  logic                sw_stby,
  input  logic                man_rst,
  input  logic                clk_mode,
  input  logic                sysclk_lvl,
  input  logic                bus_claim,
  input  logic [BUS_PINS-1:0] bus_oe,
  input  logic [BUS_PINS-1:0] bus_out,
  input  logic [1:0]          addr,
  input  logic                wr_en,
  input  logic [WIDTH-1:0]    wdata,
  output logic [WIDTH-1:0]    rdata,
  input  logic [WIDTH-1:0]    pin_in,
  output logic [WIDTH-1:0]    pin_oe,
  output logic [WIDTH-1:0]    pin_out
);
  logic [WIDTH-1:0] dir_q, data_q, pin_sync;
  logic             hold;

  assign hold = man_rst || sw_stby;

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (pin_in),
    .d_sync (pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_stby (hw_stby),
    .hold    (hold),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .dir_q   (dir_q),
    .data_q  (data_q)
  );

  gpio_port_pinmux #(.WIDTH(WIDTH), .BUS_PINS(BUS_PINS)) u_mux (
    .hw_stby    (hw_stby),
    .bus_claim  (bus_claim),
    .bus_oe     (bus_oe),
    .bus_out    (bus_out),
    .clk_mode   (clk_mode),
    .sysclk_lvl (sysclk_lvl),
    .dir_q      (dir_q),
    .data_q     (data_q),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out)
  );

  always_comb begin
    unique case (gpio_addr_e'(addr))
      ADDR_DIR:  rdata = dir_q;
      ADDR_DATA: rdata = data_q;
      ADDR_PINS: rdata = (dir_q & data_q) | (~dir_q & pin_sync);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH    = 8,
  parameter int BUS_PINS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hw_stby,
  input logic                sw_stby,
  input logic                man_rst,
  input logic                bus_claim,
  input logic [BUS_PINS-1:0] bus_oe,
  input logic [BUS_PINS-1:0] bus_out,
  input logic [1:0]          addr,
  input logic                wr_en,
  input logic [WIDTH-1:0]    wdata,
  input logic [WIDTH-1:0]    rdata,
  input logic [WIDTH-1:0]    pin_oe,
  input logic [WIDTH-1:0]    pin_out,
  input logic [WIDTH-1:0]    dir_q,
  input logic [WIDTH-1:0]    data_q
);
  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !man_rst && !sw_stby && !hw_stby)
      |=> (data_q == $past(wdata)));

  // R4
  pin_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd2) |-> (((rdata ^ data_q) & dir_q) == '0));

  // R6
  hw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> (pin_oe == '0));

  // R6
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (dir_q == '0 && data_q == '0));

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((man_rst || sw_stby) && !hw_stby) |=> ($stable(dir_q) && $stable(data_q)));

  // R8
  sw_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby && !bus_claim && $past(sw_stby) && !$past(bus_claim) && !$past(hw_stby))
      |-> $stable(pin_oe));

  // R9
  bus_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_claim && !hw_stby) |-> (pin_oe[BUS_PINS-1:0] == bus_oe && pin_out[BUS_PINS-1:0] == bus_out));
endmodule

bind gpio_port_ctl gpio_port_chk #(.WIDTH(WIDTH), .BUS_PINS(BUS_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hw_stby   (hw_stby),
  .sw_stby   (sw_stby),
  .man_rst   (man_rst),
  .bus_claim (bus_claim),
  .bus_oe    (bus_oe),
  .bus_out   (bus_out),
  .addr      (addr),
  .wr_en     (wr_en),
  .wdata     (wdata),
  .rdata     (rdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .dir_q     (dir_q),
  .data_q    (data_q)
);

// File: tb/gpio_port_ctl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n, hw_stby, sw_stby, man_rst, clk_mode, sysclk_lvl, bus_claim, wr_en;
  logic [2:0] bus_oe, bus_out;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, pin_in, pin_oe, pin_out;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ctl u_gpio_port_ctl (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby), .man_rst(man_rst),
    .clk_mode(clk_mode), .sysclk_lvl(sysclk_lvl), .bus_claim(bus_claim),
    .bus_oe(bus_oe), .bus_out(bus_out), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  // {dir, data, pin, expected pin view}; pin_oe expected = dir, pin_out = data
  localparam logic [31:0] VEC [5] = '{
    {8'h00, 8'hFF, 8'hA5, 8'hA5},
    {8'hFF, 8'h3C, 8'h00, 8'h3C},
    {8'hF0, 8'hAA, 8'h55, 8'hA5},
    {8'h0F, 8'h96, 8'h69, 8'h66},
    {8'h5A, 8'hC3, 8'h3C, 8'h66}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; hw_stby = 0; sw_stby = 0; man_rst = 0; clk_mode = 0; sysclk_lvl = 0;
    bus_claim = 0; bus_oe = 0; bus_out = 0; addr = 0; wr_en = 0; wdata = 0; pin_in = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(2'd0, r); chk("R1 dir", r, 8'h00);
    rd(2'd1, r); chk("R1 data", r, 8'h00);
    chk("R1 oe", pin_oe, 8'h00);

    // R2 R3 R4 vector table
    foreach (VEC[k]) begin
      wr(2'd0, VEC[k][31:24]);
      wr(2'd1, VEC[k][23:16]);
      pin_in = VEC[k][15:8];
      tick(); tick();
      rd(2'd0, r); chk("R2 dir readback", r, VEC[k][31:24]);
      rd(2'd2, r); chk("R4 pin view", r, VEC[k][7:0]);
      chk("R3 oe", pin_oe, VEC[k][31:24]);
      chk("R3 out", pin_out, VEC[k][23:16]);
    end

    // R4 two-flop delay boundary: all inputs
    wr(2'd0, 8'h00);
    pin_in = 8'h00; tick(); tick();
    pin_in = 8'hC9;
    tick(); rd(2'd2, r); chk("R4 one edge old", r, 8'h00);
    tick(); rd(2'd2, r); chk("R4 two edges new", r, 8'hC9);

    // R5 writes to address 2 and 3 ignored, address 3 reads zero
    wr(2'd0, 8'h21); wr(2'd1, 8'h43);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd0, r); chk("R5 dir kept", r, 8'h21);
    rd(2'd1, r); chk("R5 data kept", r, 8'h43);
    rd(2'd3, r); chk("R5 addr3 zero", r, 8'h00);

    // R7 manual reset retains, blocks writes
    man_rst = 1'b1;
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    rd(2'd0, r); chk("R7 dir kept", r, 8'h21);
    rd(2'd1, r); chk("R7 data kept", r, 8'h43);
    man_rst = 1'b0;

    // R8 software standby retains, outputs held
    sw_stby = 1'b1;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    rd(2'd0, r); chk("R8 dir kept", r, 8'h21);
    rd(2'd1, r); chk("R8 data kept", r, 8'h43);
    chk("R8 oe held", pin_oe, 8'h21);
    chk("R8 out held", pin_out, 8'h43);
    sw_stby = 1'b0;

    // R6 hardware standby clears and releases pins
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    hw_stby = 1'b1;
    #1 chk("R6 oe released", pin_oe, 8'h00);
    wr(2'd1, 8'h77);
    hw_stby = 1'b0;
    rd(2'd0, r); chk("R6 dir cleared", r, 8'h00);
    rd(2'd1, r); chk("R6 data cleared", r, 8'h00);

    // R9 bus claim on pins 2..0
    wr(2'd0, 8'h00); wr(2'd1, 8'hFF);
    bus_claim = 1'b1; bus_oe = 3'b101; bus_out = 3'b011;
    #1;
    chk("R9 oe low pins", {5'd0, pin_oe[2:0]}, 8'h05);
    chk("R9 out low pins", {5'd0, pin_out[2:0]}, 8'h03);
    wr(2'd0, 8'h02);
    rd(2'd0, r); chk("R9 dir unaffected", r, 8'h02);
    chk("R9 oe still bus", {5'd0, pin_oe[2:0]}, 8'h05);
    bus_claim = 1'b0; bus_oe = 0; bus_out = 0;
    #1 chk("R9 released to regs", {5'd0, pin_oe[2:0]}, 8'h02);

    // R10 clock output on pin 7
    wr(2'd0, 8'h81); wr(2'd1, 8'h00);
    clk_mode = 1'b1; sysclk_lvl = 1'b1;
    #1;
    chk("R10 clk high", {7'd0, pin_out[7]}, 8'h01);
    chk("R10 pin0 normal", {7'd0, pin_out[0]}, 8'h00);
    chk("R10 oe", pin_oe, 8'h81);
    sysclk_lvl = 1'b0;
    #1 chk("R10 clk low", {7'd0, pin_out[7]}, 8'h00);
    sysclk_lvl = 1'b1;
    wr(2'd0, 8'h01);
    chk("R10 dir0 no enable", {7'd0, pin_oe[7]}, 8'h00);
    clk_mode = 1'b0;

    // R1 reset again after activity
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    rd(2'd1, r); chk("R1 data after reset", r, 8'h00);
    chk("R1 oe after reset", pin_oe, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule